// File: doc/BRIEF.md
# Dual Loop Code Detector

The block watches one received serial bit stream for two repeating codes at once. Software programs them as a loop-up code and a loop-down code. Each code is held as a 16-bit word, made of a high byte and a low byte, plus a 3-bit length selector. Each code has its own detector channel, and both channels see the same bits.

A bit counts only in a cycle where the bit-rate enable is high. Each channel follows the phase of the incoming repetition, counts the bits that disagree with the code, and judges the stream over a fixed window of `WINDOW_BITS` enabled bits. The default window is 74112 bits, which is 48 ms at 1.544 Mb/s. A window that ends with few enough disagreements sets the channel's detect flag. A window that ends with too many clears it. Scattered bit errors at rates around one in a hundred do not stop detection.

Phase is acquired without a training step. A history of the most recent received bits is kept. When a bit disagrees with the code, the channel tests whether that history matches the code at some rotation. If it does, the channel jumps to that rotation.

Top module: `loop_code_detector`

## Requirements
- R1: While `rst_n` is low at a clock edge, both detect outputs are 0 from that edge on.
- R2: A length selector value v from 0 to 6 gives a code of v+2 bits, and v = 7 gives 16 bits. The code is the word {high byte, low byte} read from bit 15 downward, so code position p is word bit 15-p. A code of length L repeats positions 0 to L-1 in that order. A 1-bit code is written as a 2-bit code with both bits equal.
- R3: A window closes on the `WINDOW_BITS`-th counted enabled bit after a restart or after the previous window. At that edge the flag is set when the window's disagreements number no more than `WINDOW_BITS >> 6`.
- R4: A window that closes with more than `WINDOW_BITS >> 6` disagreements clears the flag.
- R5: A flag changes only at a window close or a restart. Cycles with `bit_en` low leave all detection state and both flags unchanged, whatever `rx_bit` does.
- R6: If any field of a channel's configuration differs from its value at the previous edge, counting the all-zero value held after reset, that channel restarts. Its flag, window count, disagreement count and phase are cleared at that edge. A bit enabled in that cycle is not counted.
- R7: Each channel compares every counted bit with the code at its current phase. If they agree, the phase advances modulo L. If they disagree and the last L received bits, the new bit included, equal L consecutive code positions ending at position q-1 (taken cyclically), the phase becomes the smallest such q. Otherwise the phase advances.
- R8: The two channels work independently on the same input bits. A code seen by one channel has no effect on the other channel's flag.
- R9: Isolated single-bit errors in a locked code stream do not move the phase. Up to `WINDOW_BITS >> 6` errors in a window still leave the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_en | input | 1 | Marks the cycle that carries a received bit |
| rx_bit | input | 1 | Received data bit |
| up_code_hi | input | 8 | Loop-up code, bits 15..8 of the code word |
| up_code_lo | input | 8 | Loop-up code, bits 7..0 of the code word |
| up_len_sel | input | 3 | Loop-up code length selector |
| dn_code_hi | input | 8 | Loop-down code, bits 15..8 of the code word |
| dn_code_lo | input | 8 | Loop-down code, bits 7..0 of the code word |
| dn_len_sel | input | 3 | Loop-down code length selector |
| loop_up_det | output | 1 | Loop-up code detected in the last complete window |
| loop_dn_det | output | 1 | Loop-down code detected in the last complete window |

## Verification
A clean 5-bit loop-up code entering at an arbitrary phase shows that phase is acquired, and that the 8-bit loop-down channel stays clear on the same bits. The same stream with one bit flipped every 80 bits separates error tolerance from exact matching. Feeding it against a 6-bit length setting shows that the length selector matters. A 16-bit loop-down code against a 2-bit loop-up code exercises the longest rotation search. Random data, and long stretches with the enable held low while `rx_bit` toggles, separate a failing window from a held flag.

// File: rtl/lcd_pkg.sv
// Shared types and helpers for the dual loop code detector.
// Assumes codes are at most two register bytes long, read from the top bit down.
package lcd_pkg;
    localparam int REG_W   = 8;
    localparam int MAX_LEN = 2 * REG_W;
    localparam int SEL_W   = 3;

    typedef struct packed {
        logic [REG_W-1:0] hi;
        logic [REG_W-1:0] lo;
        logic [SEL_W-1:0] len_sel;
    } code_cfg_t;

    // Length in bits selected by the 3-bit field (7 means the full word).
    function automatic int code_len(input logic [SEL_W-1:0] sel);
        return (sel == SEL_W'(7)) ? MAX_LEN : int'(sel) + 2;
    endfunction

    // Code bit at position idx, where position 0 is the top bit of the word.
    function automatic logic code_bit(input code_cfg_t cfg, input int idx);
        logic [MAX_LEN-1:0] word;
        word = {cfg.hi, cfg.lo};
        return word[MAX_LEN-1-idx];
    endfunction
endpackage

// File: rtl/lcd_phase_tracker.sv
// Phase tracker: compares each counted bit with the code at a running phase
// and re-aligns on a disagreement when recent history matches a rotation.
// Assumes cfg is stable except in cycles where restart is high.
module lcd_phase_tracker
    import lcd_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      restart,
    input  logic      bit_en,
    input  logic      bit_in,
    input  code_cfg_t cfg,
    output logic      miss
);
    localparam int PW = $clog2(MAX_LEN);
    localparam int UW = $clog2(2 * MAX_LEN);

    logic [PW-1:0]        phase_q, phase_d;
    logic [MAX_LEN-1:0]   hist_q, hist_new;
    logic [2*MAX_LEN-1:0] unrolled;
    logic [MAX_LEN-1:0]   rot_ok;
    int                   len;

    // Selected code length.
    always_comb len = code_len(cfg.len_sel);

    // Newest received bit enters at index 0.
    always_comb hist_new = {hist_q[MAX_LEN-2:0], bit_in};

    // The code repeated over twice the longest length, so rotations are plain slices.
    always_comb begin
        int j;
        j = 0;
        for (int k = 0; k < 2 * MAX_LEN; k++) begin
            unrolled[k] = code_bit(cfg, j);
            j = (j == len - 1) ? 0 : j + 1;
        end
    end

    // rot_ok[q]: the last len bits equal the code positions that end just before q.
    always_comb begin
        for (int q = 0; q < MAX_LEN; q++) begin
            rot_ok[q] = (q < len);
            for (int i = 0; i < MAX_LEN; i++) begin
                if (i < len && hist_new[i] != unrolled[UW'(q + len - 1 - i)])
                    rot_ok[q] = 1'b0;
            end
        end
    end

    // Disagreement between the counted bit and the expected code bit.
    always_comb miss = bit_en && (bit_in != code_bit(cfg, int'(phase_q)));

    // Next phase: advance, or jump to the smallest matching rotation after a disagreement.
    always_comb begin
        phase_d = (int'(phase_q) == len - 1) ? '0 : phase_q + 1'b1;
        if (miss) begin
            for (int q = MAX_LEN - 1; q >= 0; q--)
                if (rot_ok[q]) phase_d = PW'(q);
        end
    end

    // History and phase registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
            hist_q  <= '0;
        end else begin
            if (bit_en) hist_q <= hist_new;
            if (restart)     phase_q <= '0;
            else if (bit_en) phase_q <= phase_d;
        end
    end
endmodule

// File: rtl/lcd_window_judge.sv
// Window judge: counts enabled bits and disagreements over a fixed window
// and sets or clears the detect flag when the window closes.
// Assumes WINDOW_BITS is at least 2; the disagreement count saturates at THRESH+1.
module lcd_window_judge #(
    parameter int WINDOW_BITS = 74112,
    parameter int THRESH      = WINDOW_BITS >> 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic bit_en,
    input  logic miss,
    output logic pass_q
);
    localparam int CW = $clog2(WINDOW_BITS);
    localparam int MW = $clog2(THRESH + 2);

    logic [CW-1:0] cnt_q;
    logic [MW-1:0] miss_q, miss_sum;
    logic          last;

    // Closing bit of the window.
    always_comb last = (cnt_q == CW'(WINDOW_BITS - 1));

    // Disagreement count including this bit, saturating one above the limit.
    always_comb miss_sum = (miss && miss_q <= MW'(THRESH)) ? miss_q + 1'b1 : miss_q;

    // Window counters and verdict.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            cnt_q  <= '0;
            miss_q <= '0;
            pass_q <= 1'b0;
        end else if (bit_en) begin
            if (last) begin
                pass_q <= (miss_sum <= MW'(THRESH));
                cnt_q  <= '0;
                miss_q <= '0;
            end else begin
                cnt_q  <= cnt_q + 1'b1;
                miss_q <= miss_sum;
            end
        end
    end
endmodule

// File: rtl/lcd_code_channel.sv
// One code channel: holds the applied configuration, restarts on any change,
// and joins the phase tracker to the window judge.
// Assumes configuration inputs are synchronous to clk.
module lcd_code_channel
    import lcd_pkg::*;
#(
    parameter int WINDOW_BITS = 74112,
    parameter int THRESH      = WINDOW_BITS >> 6
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      bit_en,
    input  logic      bit_in,
    input  code_cfg_t cfg_in,
    output logic      detected
);
    code_cfg_t cfg_q;
    logic      restart;
    logic      miss;
    logic      count_en;

    // A change of any configuration field restarts the channel.
    always_comb restart = (cfg_in != cfg_q);

    // A bit arriving with a restart is not counted.
    always_comb count_en = bit_en && !restart;

    // Applied configuration.
    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_in;
    end

    lcd_phase_tracker u_tracker (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .bit_en  (bit_en),
        .bit_in  (bit_in),
        .cfg     (cfg_q),
        .miss    (miss)
    );

    lcd_window_judge #(
        .WINDOW_BITS (WINDOW_BITS),
        .THRESH      (THRESH)
    ) u_judge (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .bit_en  (count_en),
        .miss    (miss),
        .pass_q  (detected)
    );
endmodule

// File: rtl/loop_code_detector.sv
// Dual loop code detector top: one channel each for the loop-up and the
// loop-down code, both fed by the same received bit stream.
// Assumes bit_en marks exactly one cycle per received bit.
module loop_code_detector
    import lcd_pkg::*;
#(
    parameter int WINDOW_BITS = 74112
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_en,
    input  logic             rx_bit,
    input  logic [REG_W-1:0] up_code_hi,
    input  logic [REG_W-1:0] up_code_lo,
    input  logic [SEL_W-1:0] up_len_sel,
    input  logic [REG_W-1:0] dn_code_hi,
    input  logic [REG_W-1:0] dn_code_lo,
    input  logic [SEL_W-1:0] dn_len_sel,
    output logic             loop_up_det,
    output logic             loop_dn_det
);
    localparam int NUM_CODES = 2;
    localparam int UP_IDX    = 0;
    localparam int DN_IDX    = 1;
    localparam int THRESH    = WINDOW_BITS >> 6;

    code_cfg_t              cfg_arr [NUM_CODES];
    logic [NUM_CODES-1:0]   det;

    // Gather each code's configuration.
    always_comb begin
        cfg_arr[UP_IDX] = {up_code_hi, up_code_lo, up_len_sel};
        cfg_arr[DN_IDX] = {dn_code_hi, dn_code_lo, dn_len_sel};
    end

    for (genvar g = 0; g < NUM_CODES; g++) begin : g_chan
        lcd_code_channel #(
            .WINDOW_BITS (WINDOW_BITS),
            .THRESH      (THRESH)
        ) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .bit_en   (bit_en),
            .bit_in   (rx_bit),
            .cfg_in   (cfg_arr[g]),
            .detected (det[g])
        );
    end

    assign loop_up_det = det[UP_IDX];
    assign loop_dn_det = det[DN_IDX];
endmodule

// File: rtl/lcd_checker.sv
// Protocol checker for loop_code_detector: reset, restart and window-timing
// properties seen from the ports. Keeps its own window counters.
module lcd_checker #(
    parameter int WINDOW_BITS = 74112
) (
    input logic       clk,
    input logic       rst_n,
    input logic       bit_en,
    input logic [7:0] up_code_hi,
    input logic [7:0] up_code_lo,
    input logic [2:0] up_len_sel,
    input logic [7:0] dn_code_hi,
    input logic [7:0] dn_code_lo,
    input logic [2:0] dn_len_sel,
    input logic       loop_up_det,
    input logic       loop_dn_det
);
    logic [18:0] up_prev, dn_prev;
    logic        up_chg, dn_chg;
    int          up_cnt, dn_cnt;
    logic        up_end, dn_end;

    // Configuration change seen at the ports.
    always_comb begin
        up_chg = ({up_code_hi, up_code_lo, up_len_sel} != up_prev);
        dn_chg = ({dn_code_hi, dn_code_lo, dn_len_sel} != dn_prev);
        up_end = bit_en && !up_chg && (up_cnt == WINDOW_BITS - 1);
        dn_end = bit_en && !dn_chg && (dn_cnt == WINDOW_BITS - 1);
    end

    // Previous configuration and independent window counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            up_prev <= '0;
            dn_prev <= '0;
            up_cnt  <= 0;
            dn_cnt  <= 0;
        end else begin
            up_prev <= {up_code_hi, up_code_lo, up_len_sel};
            dn_prev <= {dn_code_hi, dn_code_lo, dn_len_sel};
            if (up_chg)      up_cnt <= 0;
            else if (bit_en) up_cnt <= up_end ? 0 : up_cnt + 1;
            if (dn_chg)      dn_cnt <= 0;
            else if (bit_en) dn_cnt <= dn_end ? 0 : dn_cnt + 1;
        end
    end

    AST_RESET_CLEARS: assert property (@(posedge clk) !rst_n |=> (!loop_up_det && !loop_dn_det)); // R1
    AST_UP_CHG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) up_chg |=> !loop_up_det); // R6
    AST_DN_CHG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) dn_chg |=> !loop_dn_det); // R6
    AST_UP_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!bit_en && !up_chg) |=> $stable(loop_up_det)); // R5
    AST_DN_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!bit_en && !dn_chg) |=> $stable(loop_dn_det)); // R5
    AST_UP_RISE_AT_CLOSE: assert property (@(posedge clk) disable iff (!rst_n) !up_end |=> !$rose(loop_up_det)); // R3
    AST_DN_RISE_AT_CLOSE: assert property (@(posedge clk) disable iff (!rst_n) !dn_end |=> !$rose(loop_dn_det)); // R3
    AST_UP_FALL_AT_CLOSE: assert property (@(posedge clk) disable iff (!rst_n) (!up_end && !up_chg) |=> !$fell(loop_up_det)); // R4
endmodule

bind loop_code_detector lcd_checker #(.WINDOW_BITS(WINDOW_BITS)) u_lcd_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .bit_en      (bit_en),
    .up_code_hi  (up_code_hi),
    .up_code_lo  (up_code_lo),
    .up_len_sel  (up_len_sel),
    .dn_code_hi  (dn_code_hi),
    .dn_code_lo  (dn_code_lo),
    .dn_len_sel  (dn_len_sel),
    .loop_up_det (loop_up_det),
    .loop_dn_det (loop_dn_det)
);

// File: tb/loop_code_detector_bench.sv
`timescale 1ns/1ps
// Bench: a behavioural model of both channels, built from queues and integers,
// compared with the outputs on every clock, plus named checks at scenario ends.
module loop_code_detector_bench;
    localparam int W = 128;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b0;
    logic       rx_bit = 1'b0;
    logic [7:0] up_hi = '0, up_lo = '0, dn_hi = '0, dn_lo = '0;
    logic [2:0] up_len = '0, dn_len = '0;
    logic       loop_up_det, loop_dn_det;

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R1";
    bit    cmp_on = 1'b0;
    int    pos = 0;

    always #2.5 clk = ~clk;

    loop_code_detector #(.WINDOW_BITS(W)) u_loop_code_detector (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_bit(rx_bit),
        .up_code_hi(up_hi), .up_code_lo(up_lo), .up_len_sel(up_len),
        .dn_code_hi(dn_hi), .dn_code_lo(dn_lo), .dn_len_sel(dn_len),
        .loop_up_det(loop_up_det), .loop_dn_det(loop_dn_det)
    );

    // ---------------- reference model ----------------
    int          m_phase [2];
    int          m_cnt   [2];
    int          m_miss  [2];
    bit          m_st    [2];
    logic [18:0] m_cfg   [2];
    bit          hist_q  [$];

    function automatic int lenof(logic [2:0] s);
        return (s == 3'd7) ? 16 : int'(s) + 2;
    endfunction

    function automatic bit pat(logic [18:0] c, int idx);
        logic [15:0] w;
        w = c[18:3];
        return w[15 - idx];
    endfunction

    task automatic model_bit(int ch);
        int L = lenof(m_cfg[ch][2:0]);
        int hit = -1;
        bit m;
        m = (rx_bit != pat(m_cfg[ch], m_phase[ch]));
        if (m) begin
            for (int q = 0; q < L && hit < 0; q++) begin
                bit ok = 1'b1;
                for (int i = 0; i < L; i++) begin
                    bit h = (i == 0) ? rx_bit : hist_q[i - 1];
                    if (h != pat(m_cfg[ch], (q - 1 - i + 2 * L) % L)) ok = 1'b0;
                end
                if (ok) hit = q;
            end
        end
        m_phase[ch] = (hit >= 0) ? hit : (m_phase[ch] + 1) % L;
        m_miss[ch] += int'(m);
        m_cnt[ch]++;
        if (m_cnt[ch] == W) begin
            m_st[ch]   = (m_miss[ch] <= W / 64);
            m_cnt[ch]  = 0;
            m_miss[ch] = 0;
        end
    endtask

    always @(posedge clk) begin
        logic [18:0] cur [2];
        cur[0] = {up_hi, up_lo, up_len};
        cur[1] = {dn_hi, dn_lo, dn_len};
        if (!rst_n) begin
            for (int ch = 0; ch < 2; ch++) begin
                m_phase[ch] = 0; m_cnt[ch] = 0; m_miss[ch] = 0;
                m_st[ch] = 1'b0; m_cfg[ch] = '0;
            end
            hist_q = {};
            for (int i = 0; i < 16; i++) hist_q.push_back(1'b0);
        end else begin
            for (int ch = 0; ch < 2; ch++) begin
                if (cur[ch] != m_cfg[ch]) begin
                    m_phase[ch] = 0; m_cnt[ch] = 0; m_miss[ch] = 0; m_st[ch] = 1'b0;
                end else if (bit_en) begin
                    model_bit(ch);
                end
                m_cfg[ch] = cur[ch];
            end
            if (bit_en) begin
                hist_q.push_front(rx_bit);
                void'(hist_q.pop_back());
            end
        end
    end

    // Per-cycle comparison away from the active edge.
    always @(negedge clk) begin
        if (cmp_on) begin
            checks++;
            if (loop_up_det !== m_st[0] || loop_dn_det !== m_st[1]) begin
                errors++;
                $display("FAIL %s cycle compare: actual up=%b dn=%b expected up=%b dn=%b",
                         cur_req, loop_up_det, loop_dn_det, m_st[0], m_st[1]);
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic chk(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic send_bit(bit b);
        @(negedge clk);
        bit_en = 1'b1;
        rx_bit = b;
        @(negedge clk);
        bit_en = 1'b0;
        rx_bit = 1'($urandom_range(1, 0));
    endtask

    task automatic send_code(logic [15:0] w, int L, int nbits, int err_every);
        for (int n = 0; n < nbits; n++) begin
            bit b = w[15 - (pos % L)];
            if (err_every > 0 && (n % err_every) == err_every - 1) b = ~b;
            send_bit(b);
            pos++;
        end
    endtask

    task automatic send_random(int nbits);
        for (int n = 0; n < nbits; n++) send_bit(1'($urandom_range(1, 0)));
    endtask

    // ---------------- scenario ----------------
    initial begin
        repeat (4) @(negedge clk);
        cmp_on = 1'b1;
        chk("R1 up after reset", loop_up_det, 1'b0);
        chk("R1 dn after reset", loop_dn_det, 1'b0);
        rst_n = 1'b1;

        // 5-bit loop-up code entering mid-pattern; 8-bit loop-down code differs.
        cur_req = "R7";
        up_hi = 8'h80; up_lo = 8'h00; up_len = 3'd3;
        dn_hi = 8'hA5; dn_lo = 8'h00; dn_len = 3'd6;
        pos = 2;
        send_code(16'h8000, 5, 4 * W, 0);
        chk("R3 R7 up locks from arbitrary phase", loop_up_det, 1'b1);
        chk("R8 dn stays clear", loop_dn_det, 1'b0);

        // Sparse single-bit errors.
        cur_req = "R9";
        send_code(16'h8000, 5, 4 * W, 80);
        chk("R9 up tolerates sparse errors", loop_up_det, 1'b1);

        // Configuration change restarts the channel.
        cur_req = "R6";
        @(negedge clk);
        up_len = 3'd4;
        @(negedge clk);
        chk("R6 up cleared on change", loop_up_det, 1'b0);
        cur_req = "R2";
        send_code(16'h8000, 5, 3 * W, 0);
        chk("R2 wrong length fails", loop_up_det, 1'b0);
        @(negedge clk);
        up_len = 3'd3;
        send_code(16'h8000, 5, 3 * W, 0);
        chk("R2 right length passes", loop_up_det, 1'b1);

        // 16-bit loop-down code; loop-up set to a 2-bit code.
        cur_req = "R8";
        @(negedge clk);
        dn_hi = 8'hF0; dn_lo = 8'hC3; dn_len = 3'd7;
        up_hi = 8'h80; up_lo = 8'h00; up_len = 3'd0;
        pos = 7;
        send_code(16'hF0C3, 16, 4 * W, 0);
        chk("R2 dn 16-bit code detected", loop_dn_det, 1'b1);
        chk("R8 up clear on other code", loop_up_det, 1'b0);

        // Enable held low while data toggles.
        cur_req = "R5";
        repeat (300) begin
            @(negedge clk);
            rx_bit = 1'($urandom_range(1, 0));
        end
        chk("R5 dn held with enable low", loop_dn_det, 1'b1);
        chk("R5 up held with enable low", loop_up_det, 1'b0);

        // Random data fails both windows.
        cur_req = "R4";
        send_random(4 * W);
        chk("R4 dn cleared by failing window", loop_dn_det, 1'b0);
        chk("R4 up stays clear", loop_up_det, 1'b0);

        // 2-bit alternating code.
        cur_req = "R3";
        pos = 1;
        send_code(16'h8000, 2, 3 * W, 0);
        chk("R3 up 2-bit code detected", loop_up_det, 1'b1);
        chk("R8 dn clear on 2-bit stream", loop_dn_det, 1'b0);

        @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule